// File: doc/BRIEF.md
# Graphics command packet assembler

The assembler sits behind the data port of a drawing engine. Software or a DMA engine pushes a stream of 32-bit words into it. The assembler groups those words into whole command packets before anything downstream acts on them. The first word of a packet carries the opcode in its top byte. The assembler looks up how many extra words that opcode needs, collects them into a packet buffer, and then raises a single-cycle dispatch strobe. While the strobe is raised, the opcode, the buffered words and the stored word count are presented to the rasterizer.

After a dispatch, the input stays blocked until the consumer acknowledges the packet. Writes on the control port can throw away a packet that is only partly assembled, so the next data word is taken as a fresh opcode word.

Top module: `cmd_packet_asm`

## Requirements
- R1: After reset, `in_ready` is 1, `pkt_strobe` is 0 and `pkt_len` is 0.
- R2: A data word accepted while no packet is pending becomes word 0 of a new packet, and its bits 31:24 are the opcode on `pkt_opcode`. The number of extra words is set by the opcode as follows:
  - 2 extra words: 0x02, 0x40-0x43, 0x60-0x63, 0x6C-0x6F, 0x74-0x77, 0x7C-0x7F, 0xA0, 0xC0.
  - 3 extra words: 0x20-0x23, 0x48-0x53, 0x64-0x67, 0x80.
  - 4 extra words: 0x28-0x2B, 0x58-0x5F.
  - 1 extra word: 0x68-0x6B, 0x70-0x73, 0x78-0x7B.
  - 5, 6, 7, 8 and 11 extra words: 0x30-0x33, 0x24-0x27, 0x38-0x3B, 0x2C-0x2F together with 0x34-0x37, and 0x3C-0x3F respectively.
  - 0 extra words: every other opcode.
- R3: An opcode with zero extra words is dispatched as a one-word packet. `pkt_strobe` is 1 in the cycle after that word is accepted, and `pkt_len` is 1.
- R4: Each further accepted word goes to the next buffer index k, which is bits [32k+31:32k] of `pkt_words`. The strobe stays 0 until the last extra word is accepted. It is 1 in the cycle after that, with `pkt_len` equal to 1 plus the extra count.
- R5: `pkt_strobe` lasts exactly one cycle. From the strobe onward, `in_ready` is 0 and the packet outputs hold steady until `pkt_ack` is seen. `in_ready` is 1 again in the cycle after the acknowledge.
- R6: A control write with top byte 0x01, with top byte 0x02, or with the exact value 0x04000000 discards a partly assembled packet, so the next data word starts a new packet. Any other control value, such as 0x04000001 or 0x03000001, leaves the packet in progress untouched.
- R7: When a discarding control write and a data word arrive in the same cycle, the data word is dropped.
- R8: Buffer slots beyond `pkt_len` read as zero when a packet is dispatched.
- R9: A discarding control write that arrives while a completed packet waits for acknowledge leaves that packet and its outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data word offered |
| in_data | input | 32 | Data word |
| in_ready | output | 1 | Word can be accepted this cycle |
| ctl_we | input | 1 | Control-port write strobe |
| ctl_data | input | 32 | Control-port write value |
| pkt_strobe | output | 1 | One-cycle dispatch pulse |
| pkt_opcode | output | 8 | Opcode of the packet |
| pkt_words | output | 384 | Packet buffer, word k at bits [32k+31:32k] |
| pkt_len | output | 4 | Number of stored words |
| pkt_ack | input | 1 | Consumer has taken the packet |

## Verification
The bench goes after the following corner cases:
- **Opcode table boundaries.** It drives random opcodes across the whole 256-value space. A wrong range would show up as an early or late strobe.
- **Stale buffer contents.** It sends a long packet followed by a short one. A buffer that failed to clear would leave old words in the unused slots.
- **Control-port discards.** It issues all three discarding control values in the middle of a packet, plus two near-miss values. A decoder that was too loose or too strict would either merge the words of two packets or lose a packet in progress.
- **Simultaneous discard and data.** It presents a zero-extra opcode word together with a discard. If the word leaked through, a spurious dispatch would appear.
- **Delayed acknowledge.** It holds off acknowledge, including during a discard, and expects the outputs to stay frozen with the input blocked throughout.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;
  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } cpa_state_e;
endpackage

// File: rtl/cpa_len_lut.sv
`timescale 1ns/1ps
module cpa_len_lut #(
  parameter int CW = 4
) (
  input  logic [cpa_pkg::OPC_W-1:0] opcode,
  output logic [CW-1:0]             extra
);
  logic [3:0] v;

  // Opcode groups: top three bits pick a family, bits 4:2 pick a sub-group.
  always_comb begin
    v = 4'd0;
    unique case (opcode[7:5])
      3'b000: v = (opcode == 8'h02) ? 4'd2 : 4'd0;
      3'b001: begin
        unique case (opcode[4:2])
          3'd0: v = 4'd3;
          3'd1: v = 4'd6;
          3'd2: v = 4'd4;
          3'd3: v = 4'd8;
          3'd4: v = 4'd5;
          3'd5: v = 4'd8;
          3'd6: v = 4'd7;
          3'd7: v = 4'd11;
          default: v = 4'd0;
        endcase
      end
      3'b010: begin
        unique case (opcode[4:2])
          3'd0: v = 4'd2;
          3'd1: v = 4'd0;
          3'd2, 3'd3, 3'd4: v = 4'd3;
          3'd5: v = 4'd0;
          3'd6, 3'd7: v = 4'd4;
          default: v = 4'd0;
        endcase
      end
      3'b011: begin
        unique case (opcode[4:2])
          3'd0: v = 4'd2;
          3'd1: v = 4'd3;
          default: v = opcode[2] ? 4'd2 : 4'd1;
        endcase
      end
      3'b100: v = (opcode == 8'h80) ? 4'd3 : 4'd0;
      3'b101: v = (opcode == 8'hA0) ? 4'd2 : 4'd0;
      3'b110: v = (opcode == 8'hC0) ? 4'd2 : 4'd0;
      default: v = 4'd0;
    endcase
  end

  assign extra = CW'(v);
endmodule

// File: rtl/cpa_ctl_decode.sv
`timescale 1ns/1ps
module cpa_ctl_decode #(
  parameter int DW = 32
) (
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_data,
  output logic          flush
);
  localparam int TOP = DW - 8;
  localparam logic [DW-1:0] EXACT_CLR = DW'(32'h0400_0000);

  logic [7:0] cmd;
  logic       by_cmd;
  logic       by_val;

  assign cmd    = ctl_data[DW-1:TOP];
  assign by_cmd = (cmd == 8'h01) || (cmd == 8'h02);
  assign by_val = (ctl_data == EXACT_CLR);
  assign flush  = ctl_we && (by_cmd || by_val);
endmodule

// File: rtl/cpa_seq.sv
`timescale 1ns/1ps
module cpa_seq #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 12,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  input  logic                      flush,
  input  logic                      pkt_ack,
  input  logic [CW-1:0]             lut_extra,
  output logic [cpa_pkg::OPC_W-1:0] cur_op,
  output logic                      in_ready,
  output logic                      wr_en,
  output logic [CW-1:0]             wr_idx,
  output logic                      start,
  output logic                      strobe,
  output logic [CW-1:0]             len
);
  import cpa_pkg::*;

  localparam int TOP = DW - OPC_W;

  cpa_state_e         state_q, state_d;
  logic [CW-1:0]      rem_q, rem_d;
  logic [CW-1:0]      idx_q, idx_d;
  logic [CW-1:0]      len_q, len_d;
  logic [OPC_W-1:0]   op_q, op_d;
  logic               stb_q, stb_d;
  logic               accept;

  assign in_ready = (state_q != ST_HOLD);
  assign accept   = in_valid && in_ready && !flush;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    len_d   = len_q;
    op_d    = op_q;
    stb_d   = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          wr_en  = 1'b1;
          wr_idx = '0;
          start  = 1'b1;
          op_d   = in_data[DW-1:TOP];
          if (lut_extra == '0) begin
            state_d = ST_HOLD;
            stb_d   = 1'b1;
            len_d   = CW'(1);
          end else begin
            state_d = ST_FILL;
            rem_d   = lut_extra;
            idx_d   = CW'(1);
          end
        end
      end
      ST_FILL: begin
        if (flush) begin
          state_d = ST_IDLE;
        end else if (accept) begin
          wr_en = 1'b1;
          idx_d = idx_q + CW'(1);
          rem_d = rem_q - CW'(1);
          if (rem_q == CW'(1)) begin
            state_d = ST_HOLD;
            stb_d   = 1'b1;
            len_d   = idx_q + CW'(1);
          end
        end
      end
      ST_HOLD: begin
        if (pkt_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      op_q    <= '0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      op_q    <= op_d;
      stb_q   <= stb_d;
    end
  end

  assign strobe = stb_q;
  assign len    = len_q;
  assign cur_op = op_q;
endmodule

// File: rtl/cpa_buf.sv
`timescale 1ns/1ps
module cpa_buf #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 12,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CW-1:0]           wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    start,
  output logic [MAX_WORDS*DW-1:0] words
);
  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_slot
    logic [DW-1:0] q, d;
    logic          hit, clr, en;

    assign hit = wr_en && (wr_idx == CW'(i));
    // Slot 0 is always rewritten on start; the rest are wiped.
    assign clr = start && (i != 0);
    assign en  = hit || clr;
    assign d   = hit ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[i*DW +: DW] = q;
  end
endmodule

// File: rtl/cmd_packet_asm.sv
`timescale 1ns/1ps
module cmd_packet_asm #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 12,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  output logic                      in_ready,
  input  logic                      ctl_we,
  input  logic [DW-1:0]             ctl_data,
  output logic                      pkt_strobe,
  output logic [cpa_pkg::OPC_W-1:0] pkt_opcode,
  output logic [MAX_WORDS*DW-1:0]   pkt_words,
  output logic [CW-1:0]             pkt_len,
  input  logic                      pkt_ack
);
  localparam int TOP = DW - cpa_pkg::OPC_W;

  logic          flush;
  logic [CW-1:0] extra;
  logic          wr_en;
  logic [CW-1:0] wr_idx;
  logic          start;

  cpa_ctl_decode #(.DW(DW)) u_dec (
    .ctl_we   (ctl_we),
    .ctl_data (ctl_data),
    .flush    (flush)
  );

  cpa_len_lut #(.CW(CW)) u_lut (
    .opcode (in_data[DW-1:TOP]),
    .extra  (extra)
  );

  cpa_seq #(.DW(DW), .MAX_WORDS(MAX_WORDS), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .flush     (flush),
    .pkt_ack   (pkt_ack),
    .lut_extra (extra),
    .cur_op    (pkt_opcode),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .start     (start),
    .strobe    (pkt_strobe),
    .len       (pkt_len)
  );

  cpa_buf #(.DW(DW), .MAX_WORDS(MAX_WORDS), .CW(CW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (in_data),
    .start   (start),
    .words   (pkt_words)
  );
endmodule

// File: rtl/cpa_checker.sv
`timescale 1ns/1ps
module cpa_checker #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 12,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [DW-1:0]           in_data,
  input logic                    in_ready,
  input logic                    ctl_we,
  input logic [DW-1:0]           ctl_data,
  input logic                    pkt_strobe,
  input logic [7:0]              pkt_opcode,
  input logic [MAX_WORDS*DW-1:0] pkt_words,
  input logic [CW-1:0]           pkt_len,
  input logic                    pkt_ack
);
  logic discard;
  assign discard = ctl_we && ((ctl_data[DW-1:DW-8] == 8'h01) ||
                              (ctl_data[DW-1:DW-8] == 8'h02) ||
                              (ctl_data == DW'(32'h0400_0000)));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_strobe |=> !pkt_strobe);

  a_r5_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_strobe |-> !in_ready);

  a_r5_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && pkt_ack) |=> in_ready);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pkt_ack) |=> ($stable(pkt_words) && $stable(pkt_len) && $stable(pkt_opcode)));

  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_strobe |-> (pkt_len != '0 && pkt_len <= CW'(MAX_WORDS)));

  a_r2_opcode_word0: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_strobe |-> (pkt_opcode == pkt_words[DW-1:DW-8]));

  a_r7_abort_drops_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && discard) |=> !pkt_strobe);
endmodule

bind cmd_packet_asm cpa_checker #(.DW(DW), .MAX_WORDS(MAX_WORDS), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_ready   (in_ready),
  .ctl_we     (ctl_we),
  .ctl_data   (ctl_data),
  .pkt_strobe (pkt_strobe),
  .pkt_opcode (pkt_opcode),
  .pkt_words  (pkt_words),
  .pkt_len    (pkt_len),
  .pkt_ack    (pkt_ack)
);

// File: tb/cmd_packet_asm_test.sv
`timescale 1ns/1ps
module cmd_packet_asm_test;
  localparam int DW = 32;
  localparam int NW = 12;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_data;
  logic            in_ready;
  logic            ctl_we;
  logic [31:0]     ctl_data;
  logic            pkt_strobe;
  logic [7:0]      pkt_opcode;
  logic [NW*DW-1:0] pkt_words;
  logic [3:0]      pkt_len;
  logic            pkt_ack;

  int n_chk;
  int n_bad;
  bit finished;

  logic [31:0] exp_w [NW];
  int          exp_n;

  cmd_packet_asm uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .pkt_strobe(pkt_strobe), .pkt_opcode(pkt_opcode), .pkt_words(pkt_words),
    .pkt_len(pkt_len), .pkt_ack(pkt_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int extra_of(logic [7:0] op);
    if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) return 2;
    if (op == 8'h80) return 3;
    if (op inside {[8'h20:8'h23], [8'h48:8'h53], [8'h64:8'h67]}) return 3;
    if (op inside {[8'h24:8'h27]}) return 6;
    if (op inside {[8'h28:8'h2B], [8'h58:8'h5F]}) return 4;
    if (op inside {[8'h2C:8'h2F], [8'h34:8'h37]}) return 8;
    if (op inside {[8'h30:8'h33]}) return 5;
    if (op inside {[8'h38:8'h3B]}) return 7;
    if (op inside {[8'h3C:8'h3F]}) return 11;
    if (op inside {[8'h40:8'h43], [8'h60:8'h63], [8'h6C:8'h6F],
                   [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
    if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic put_word(logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ctl_write(logic [31:0] v);
    ctl_we   = 1'b1;
    ctl_data = v;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic begin_pkt(logic [7:0] op);
    exp_n = extra_of(op);
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    exp_w[0] = {op, 24'($urandom)};
    for (int k = 1; k <= exp_n; k++) exp_w[k] = $urandom;
  endtask

  task automatic feed(int from, int upto);
    for (int i = from; i < upto; i++) begin
      put_word(exp_w[i]);
      if (i < exp_n) check(pkt_strobe == 1'b0, "R4", "early strobe", 32'(pkt_strobe), 0);
    end
  endtask

  task automatic check_packet();
    string rq;
    rq = (exp_n == 0) ? "R3" : "R4";
    check(pkt_strobe == 1'b1, rq, "strobe", 32'(pkt_strobe), 1);
    check(pkt_len == 4'(exp_n + 1), rq, "len", 32'(pkt_len), 32'(exp_n + 1));
    check(pkt_opcode == exp_w[0][31:24], "R2", "opcode", 32'(pkt_opcode), 32'(exp_w[0][31:24]));
    for (int k = 0; k < NW; k++)
      check(pkt_words[k*32 +: 32] == exp_w[k], (k > exp_n) ? "R8" : "R4",
            $sformatf("word %0d", k), pkt_words[k*32 +: 32], exp_w[k]);
  endtask

  task automatic finish_pkt(int delay, bit abort_in_hold);
    check_packet();
    check(in_ready == 1'b0, "R5", "ready at strobe", 32'(in_ready), 0);
    if (abort_in_hold) begin
      ctl_write(32'h0100_0000);
      delay = delay - 1;
      check(in_ready == 1'b0, "R9", "ready after hold abort", 32'(in_ready), 0);
      for (int k = 0; k < NW; k++)
        check(pkt_words[k*32 +: 32] == exp_w[k], "R9", "word after hold abort",
              pkt_words[k*32 +: 32], exp_w[k]);
    end
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check(pkt_strobe == 1'b0, "R5", "strobe width", 32'(pkt_strobe), 0);
      check(in_ready == 1'b0, "R5", "ready while held", 32'(in_ready), 0);
      check(pkt_len == 4'(exp_n + 1), "R5", "len held", 32'(pkt_len), 32'(exp_n + 1));
    end
    pkt_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_ack = 1'b0;
    check(in_ready == 1'b1, "R5", "ready after ack", 32'(in_ready), 1);
    check(pkt_strobe == 1'b0, "R5", "strobe after ack", 32'(pkt_strobe), 0);
  endtask

  task automatic run_pkt(logic [7:0] op, int delay);
    begin_pkt(op);
    feed(0, exp_n + 1);
    finish_pkt(delay, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h0C0D_E5EE));
    finished = 1'b0;
    n_chk = 0;
    n_bad = 0;
    in_valid = 1'b0;
    in_data = '0;
    ctl_we = 1'b0;
    ctl_data = '0;
    pkt_ack = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready", 32'(in_ready), 1);
    check(pkt_strobe == 1'b0, "R1", "strobe", 32'(pkt_strobe), 0);
    check(pkt_len == 4'd0, "R1", "len", 32'(pkt_len), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single-word opcodes
    run_pkt(8'h00, 0);
    run_pkt(8'hE3, 1);
    // R4 / R8: longest packet, then a short one over the old contents
    run_pkt(8'h3C, 0);
    run_pkt(8'h02, 2);
    run_pkt(8'h80, 0);

    // R6: each discarding control value mid-packet
    begin_pkt(8'h2C); feed(0, 4); ctl_write(32'h01AB_CDEF); run_pkt(8'h68, 0);
    begin_pkt(8'h3C); feed(0, 6); ctl_write(32'h0212_3456); run_pkt(8'hA0, 0);
    begin_pkt(8'h24); feed(0, 2); ctl_write(32'h0400_0000); run_pkt(8'h70, 0);

    // R6: near-miss control values leave the packet intact
    begin_pkt(8'h28); feed(0, 3); ctl_write(32'h0400_0001); ctl_write(32'h0300_0001);
    feed(3, exp_n + 1); finish_pkt(0, 1'b0);

    // R7: discard and data in the same cycle, idle case
    in_valid = 1'b1; in_data = 32'hE100_0000;
    ctl_we = 1'b1; ctl_data = 32'h0100_0000;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; ctl_we = 1'b0;
    check(pkt_strobe == 1'b0, "R7", "dropped word strobe", 32'(pkt_strobe), 0);
    check(in_ready == 1'b1, "R7", "ready", 32'(in_ready), 1);
    // R7: mid-packet, final word with discard is dropped
    begin_pkt(8'h6C); feed(0, 2);
    in_valid = 1'b1; in_data = exp_w[2];
    ctl_we = 1'b1; ctl_data = 32'h0200_0000;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; ctl_we = 1'b0;
    check(pkt_strobe == 1'b0, "R7", "mid drop strobe", 32'(pkt_strobe), 0);
    run_pkt(8'h50, 0);

    // R9: discard while a packet waits for ack
    begin_pkt(8'h64); feed(0, exp_n + 1); finish_pkt(3, 1'b1);

    // Random packets (R2)
    for (int p = 0; p < 150; p++) begin
      run_pkt(8'($urandom), int'($urandom_range(0, 3)));
    end

    summary();
  end
endmodule